// File: doc/BRIEF.md
# UART FIFO DMA Request Generator

This block drives the transmit and receive DMA request lines of a UART with 64-word FIFOs on each side. It reads the current fill level of each FIFO, a one-cycle pulse for each word pushed into the TX FIFO or popped from the RX FIFO, and a small set of configuration inputs. From these it works out which DMA mode is active, the level at which the TX side asks for data, and the trigger counts for both sides.

A request rises when its level condition is met. It then stays high until exactly one burst of words has moved, whatever the FIFO levels do in the meantime. Only after the request has dropped is the level compared again. The burst length is the programmed trigger count. When the FIFOs are switched off, the burst length is a single word. The DMA engine, the FIFOs and the serial logic all sit outside this block.

Top module: `uart_dma_req_gen`

## Requirements
- R1: `dma_mode` equals `mode_field` when `mode_sel` is 1, and `legacy_mode` is then ignored. When `mode_sel` is 0, `dma_mode` is `{1'b0, legacy_mode}`. The output follows the inputs combinationally.
- R2: While `dma_mode` is 0, both request outputs are low from the next clock edge, and any burst in progress is abandoned.
- R3: On a clock edge with `rst_n` low, both requests go low and both burst counts clear.
- R4: With `tx_thr_ovr` set, the TX threshold is `tx_thr_val`. If `tx_thr_val` plus the effective TX trigger is greater than 64, the threshold is 64 instead.
- R5: With `tx_thr_ovr` clear, the TX threshold is 64 minus the effective TX trigger.
- R6: While the TX request is low, it rises on the clock edge after `tx_level` is strictly below the TX threshold.
- R7: Once high, the TX request stays high until the effective TX trigger count of `tx_push` pulses has been seen. It drops on the edge that takes the last one. A shorter burst leaves it high.
- R8: While the RX request is low, it rises on the edge after `rx_level` is at least the effective RX trigger. It drops on the edge that takes the effective RX trigger count of `rx_pop` pulses.
- R9: A trigger value of 0 behaves as 1, and a trigger value above 64 behaves as 64.
- R10: With `fifo_en` low, the effective trigger on both sides is 1, whatever the trigger inputs hold.
- R11: `tx_push` or `rx_pop` pulses that arrive while the matching request is low are not counted toward the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fifo_en | input | 1 | FIFOs enabled; when low, every burst is one word |
| mode_sel | input | 1 | 1: take the mode from `mode_field`; 0: from `legacy_mode` |
| legacy_mode | input | 1 | One-bit mode select (mode 0 or 1) |
| mode_field | input | 2 | Two-bit mode select |
| tx_trig | input | 7 | TX trigger, in spaces |
| rx_trig | input | 7 | RX trigger, in words |
| tx_thr_ovr | input | 1 | Use `tx_thr_val` as the TX threshold |
| tx_thr_val | input | 7 | Programmed TX threshold |
| tx_level | input | 7 | TX FIFO fill level |
| rx_level | input | 7 | RX FIFO fill level |
| tx_push | input | 1 | One pulse per word written to the TX FIFO |
| rx_pop | input | 1 | One pulse per word read from the RX FIFO |
| dma_mode | output | 2 | Resolved DMA mode |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |

## Verification
Two things can fall on the same edge: the final counted word of a burst and a level that still meets the threshold. The design must drop the request for one cycle and compare again on the next cycle. It must not keep the request high. The bench provokes this by holding `tx_level` below the threshold and `rx_level` above the trigger throughout a burst. It also lets a mode change to 0 coincide with a push. The bench's behavioural model then judges, cycle by cycle, the one-cycle low gap and the count starting afresh.

// File: rtl/uart_dma_req_gen.sv
module uart_dma_req_gen #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          mode_sel,
  input  logic          legacy_mode,
  input  logic [1:0]    mode_field,
  input  logic [LW-1:0] tx_trig,
  input  logic [LW-1:0] rx_trig,
  input  logic          tx_thr_ovr,
  input  logic [LW-1:0] tx_thr_val,
  input  logic [LW-1:0] tx_level,
  input  logic [LW-1:0] rx_level,
  input  logic          tx_push,
  input  logic          rx_pop,
  output logic [1:0]    dma_mode,
  output logic          tx_dma_req,
  output logic          rx_dma_req
);

  localparam logic [LW-1:0] FULL = LW'(DEPTH);
  localparam logic [LW-1:0] ONE  = LW'(1);

  function automatic logic [LW-1:0] burst_len(input logic en, input logic [LW-1:0] t);
    if (!en || t == '0) return ONE;
    if (t > FULL)       return FULL;
    return t;
  endfunction

  logic [LW-1:0] tx_teff, rx_teff, tx_thr, tx_cnt, rx_cnt;
  logic [LW:0]   ovr_sum;
  logic          active;

  assign dma_mode = mode_sel ? mode_field : {1'b0, legacy_mode};
  assign active   = (dma_mode != 2'd0);
  assign tx_teff  = burst_len(fifo_en, tx_trig);
  assign rx_teff  = burst_len(fifo_en, rx_trig);
  assign ovr_sum  = {1'b0, tx_thr_val} + {1'b0, tx_teff};
  assign tx_thr   = !tx_thr_ovr ? (FULL - tx_teff) :
                    (ovr_sum > {1'b0, FULL}) ? FULL : tx_thr_val;

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      tx_dma_req <= 1'b0;
      tx_cnt     <= '0;
    end else if (!tx_dma_req) begin
      tx_cnt <= '0;
      if (tx_level < tx_thr) tx_dma_req <= 1'b1;
    end else if (tx_push) begin
      if (tx_cnt + ONE >= tx_teff) begin
        tx_dma_req <= 1'b0;
        tx_cnt     <= '0;
      end else begin
        tx_cnt <= tx_cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      rx_dma_req <= 1'b0;
      rx_cnt     <= '0;
    end else if (!rx_dma_req) begin
      rx_cnt <= '0;
      if (rx_level >= rx_teff) rx_dma_req <= 1'b1;
    end else if (rx_pop) begin
      if (rx_cnt + ONE >= rx_teff) begin
        rx_dma_req <= 1'b0;
        rx_cnt     <= '0;
      end else begin
        rx_cnt <= rx_cnt + ONE;
      end
    end
  end

  // R3
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!tx_dma_req && !rx_dma_req));

  // R2
  mode0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode == 2'd0) |=> (!tx_dma_req && !rx_dma_req));

  // R6
  tx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_dma_req) |-> ($past(tx_level) < $past(tx_thr)));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_dma_req && !tx_push && active) |=> tx_dma_req);

  // R8
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dma_req) |-> ($past(rx_level) >= $past(rx_teff)));

  // R8
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dma_req && !rx_pop && active) |=> rx_dma_req);

endmodule

// File: tb/uart_dma_req_gen_bench.sv
module uart_dma_req_gen_bench;
  localparam int LW = 7;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, fifo_en = 1'b1, mode_sel = 1'b0, legacy_mode = 1'b0;
  logic [1:0] mode_field = 2'd0;
  logic [LW-1:0] tx_trig = 7'd8, rx_trig = 7'd4, tx_thr_val = 7'd0;
  logic tx_thr_ovr = 1'b0, tx_push = 1'b0, rx_pop = 1'b0;
  logic [LW-1:0] tx_level = 7'd64, rx_level = 7'd0;
  logic [1:0] dma_mode;
  logic tx_dma_req, rx_dma_req;

  uart_dma_req_gen u_uart_dma_req_gen (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .mode_sel(mode_sel),
    .legacy_mode(legacy_mode), .mode_field(mode_field), .tx_trig(tx_trig),
    .rx_trig(rx_trig), .tx_thr_ovr(tx_thr_ovr), .tx_thr_val(tx_thr_val),
    .tx_level(tx_level), .rx_level(rx_level), .tx_push(tx_push), .rx_pop(rx_pop),
    .dma_mode(dma_mode), .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req));

  int checks = 0, errors = 0;
  string tag = "R3";
  int m_tx = 0, m_rx = 0, m_txn = 0, m_rxn = 0;

  function automatic int ref_mode();
    return mode_sel ? int'(mode_field) : int'(legacy_mode);
  endfunction

  function automatic int eff(int t);
    if (!fifo_en || t == 0) return 1;
    return (t > 64) ? 64 : t;
  endfunction

  function automatic int ref_thr();
    int te = eff(int'(tx_trig));
    if (!tx_thr_ovr) return 64 - te;
    return (int'(tx_thr_val) + te > 64) ? 64 : int'(tx_thr_val);
  endfunction

  always @(posedge clk) begin
    if (!rst_n || ref_mode() == 0) begin
      m_tx = 0; m_rx = 0; m_txn = 0; m_rxn = 0;
    end else begin
      if (m_tx == 0) begin
        if (int'(tx_level) < ref_thr()) begin m_tx = 1; m_txn = 0; end
      end else if (tx_push) begin
        m_txn++;
        if (m_txn >= eff(int'(tx_trig))) begin m_tx = 0; m_txn = 0; end
      end
      if (m_rx == 0) begin
        if (int'(rx_level) >= eff(int'(rx_trig))) begin m_rx = 1; m_rxn = 0; end
      end else if (rx_pop) begin
        m_rxn++;
        if (m_rxn >= eff(int'(rx_trig))) begin m_rx = 0; m_rxn = 0; end
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (int'(tx_dma_req) != m_tx || int'(rx_dma_req) != m_rx || int'(dma_mode) != ref_mode()) begin
      errors++;
      $display("FAIL %s model: tx %0d rx %0d mode %0d act, tx %0d rx %0d mode %0d exp",
               tag, tx_dma_req, rx_dma_req, dma_mode, m_tx, m_rx, ref_mode());
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic expect1(string t, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0b exp %0b", t, act, exp);
    end
  endtask

  task automatic pushes(int n);
    for (int i = 0; i < n; i++) begin tx_push = 1'b1; tick(); end
    tx_push = 1'b0;
  endtask

  task automatic pops(int n);
    for (int i = 0; i < n; i++) begin rx_pop = 1'b1; tick(); end
    rx_pop = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act running exp finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    expect1("R3", tx_dma_req, 1'b0);
    expect1("R3", rx_dma_req, 1'b0);
    rst_n = 1'b1;

    tag = "R1";
    mode_sel = 1'b1; mode_field = 2'd2; legacy_mode = 1'b1; #0;
    tick();
    expect1("R1", dma_mode == 2'd2, 1'b1);
    mode_field = 2'd0; tick();
    expect1("R1", dma_mode == 2'd0, 1'b1);
    mode_sel = 1'b0; tick();
    expect1("R1", dma_mode == 2'd1, 1'b1);

    tag = "R5";
    tx_trig = 7'd8; tx_level = 7'd56; tick(2);
    expect1("R5", tx_dma_req, 1'b0);
    tx_level = 7'd55; tick();
    expect1("R6", tx_dma_req, 1'b1);
    tag = "R7";
    pushes(5);
    expect1("R7", tx_dma_req, 1'b1);
    tick(3);
    pushes(3);
    expect1("R7", tx_dma_req, 1'b0);
    tick();
    expect1("R7", tx_dma_req, 1'b1);
    tx_level = 7'd64; pushes(8); tick(2);
    expect1("R11", tx_dma_req, 1'b0);
    tag = "R11";
    pushes(4); tx_level = 7'd10; tick(); tx_level = 7'd64; tick();
    pushes(7);
    expect1("R11", tx_dma_req, 1'b1);
    pushes(1); tick();

    tag = "R4";
    tx_thr_ovr = 1'b1; tx_thr_val = 7'd20; tx_level = 7'd20; tick(2);
    expect1("R4", tx_dma_req, 1'b0);
    tx_level = 7'd19; tick();
    expect1("R4", tx_dma_req, 1'b1);
    tx_level = 7'd64; pushes(8); tick();
    tx_thr_val = 7'd60; tx_level = 7'd63; tick();
    expect1("R4", tx_dma_req, 1'b1);
    tx_level = 7'd64; pushes(8); tick();
    tx_thr_ovr = 1'b0;

    tag = "R8";
    rx_trig = 7'd4; rx_level = 7'd3; tick(2);
    expect1("R8", rx_dma_req, 1'b0);
    rx_level = 7'd4; tick();
    expect1("R8", rx_dma_req, 1'b1);
    pops(3);
    expect1("R8", rx_dma_req, 1'b1);
    rx_level = 7'd0; pops(1);
    expect1("R8", rx_dma_req, 1'b0);
    pops(3); rx_level = 7'd9; tick(); rx_level = 7'd0;
    pops(3);
    expect1("R11", rx_dma_req, 1'b1);
    pops(1);

    tag = "R9";
    rx_trig = 7'd0; rx_level = 7'd1; tick();
    expect1("R9", rx_dma_req, 1'b1);
    rx_level = 7'd0; pops(1);
    expect1("R9", rx_dma_req, 1'b0);
    tx_trig = 7'd100; tx_level = 7'd0; tick(2);
    expect1("R9", tx_dma_req, 1'b0);
    tx_trig = 7'd8; tx_level = 7'd64;

    tag = "R10";
    fifo_en = 1'b0; rx_trig = 7'd8; rx_level = 7'd1; tick();
    expect1("R10", rx_dma_req, 1'b1);
    rx_level = 7'd0; pops(1);
    expect1("R10", rx_dma_req, 1'b0);
    fifo_en = 1'b1; rx_trig = 7'd4;

    tag = "R2";
    tx_level = 7'd0; rx_level = 7'd20; tick(2);
    pushes(2);
    mode_sel = 1'b1; mode_field = 2'd0; tx_push = 1'b1; tick(); tx_push = 1'b0;
    expect1("R2", tx_dma_req, 1'b0);
    expect1("R2", rx_dma_req, 1'b0);
    tick(3);
    mode_field = 2'd3; tick();
    pushes(7);
    expect1("R2", tx_dma_req, 1'b1);
    pushes(1);
    expect1("R2", tx_dma_req, 1'b0);

    tag = "R6";
    for (int i = 0; i < 3000; i++) begin
      if (i % 300 == 0) begin
        fifo_en = ($urandom % 4) != 0;
        mode_sel = $urandom; legacy_mode = $urandom; mode_field = $urandom;
        tx_trig = $urandom % 12; rx_trig = $urandom % 12;
        tx_thr_ovr = $urandom; tx_thr_val = $urandom;
      end
      if (i % 37 == 0) tx_level = $urandom % 65;
      if (i % 41 == 0) rx_level = $urandom % 65;
      tx_push = $urandom; rx_pop = $urandom;
      rst_n = (i % 997) != 5;
      tick();
    end
    rst_n = 1'b1; tx_push = 1'b0; rx_pop = 1'b0;
    tick(2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule